// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the control unit for a processor datapath that runs each instruction over several clock cycles. It shares one memory, one ALU and a set of holding registers across those cycles. A state register and combinational logic walk each instruction through a short series of steps. Every instruction begins with the same two steps: the instruction fetch, then decode and operand read. After decode, the opcode chooses a path of one to three further steps. Each step drives a fixed set of strobes and multiplexer selects into the datapath.

The datapath supplies the opcode held in its instruction register and a flag that says its two register operands are equal. The controller returns the strobes for memory, register file, ALU and program counter. It also returns a single program-counter load enable, which already folds in the equality flag for a conditional branch. The branch target is computed and stored during decode, so a branch needs only one extra step. An instruction therefore takes three to five cycles in all.

Top module: `mc_seq_ctrl`

## Requirements
- R1: A synchronous reset puts the controller in the fetch step, so in the cycle after a reset edge the outputs show the fetch strobes.
- R2: The fetch step asserts mem_rd, ir_we and pc_we with alu_b_sel=01 (constant four), alu_a_reg=0 and pc_src=00 (ALU result). It is always followed by the decode step.
- R3: The decode step asserts tgt_we with alu_a_reg=0 and alu_b_sel=11 (shifted offset). Opcode 000000 is register-type, 100011 is load, 101011 is store, 000100 is branch-if-equal and 000010 is jump. Any other opcode goes straight back to fetch, giving a two-cycle pass.
- R4: A load runs five cycles. After fetch and decode come address compute (alu_a_reg=1, alu_b_sel=10), memory read (mem_rd=1, addr_from_alu=1) and write-back (rf_we=1, wb_from_mem=1, rf_dst_rd=0). Fetch follows.
- R5: A store runs four cycles. After fetch and decode come address compute and then a memory write (mem_wr=1, addr_from_alu=1). Fetch follows.
- R6: A register-type instruction runs four cycles. After fetch and decode come ALU execute (alu_a_reg=1, alu_b_sel=00, alu_op=10) and completion (rf_we=1, rf_dst_rd=1, wb_from_mem=0). Fetch follows.
- R7: A branch runs three cycles. Its execute step asserts pc_we_cond with pc_src=01 (target), alu_op=01 (compare), alu_a_reg=1 and alu_b_sel=00. It asserts pc_load only when ops_equal is 1.
- R8: A jump runs three cycles. Its execute step asserts pc_we and pc_load with pc_src=10 (jump field) and nothing else.
- R9: pc_load equals pc_we, or pc_we_cond together with ops_equal. In any step other than the branch step, ops_equal has no effect on any output.
- R10: A strobe not named for a step is 0 in that step, and a select not named is 00 or 0. mem_rd and mem_wr are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the held instruction |
| ops_equal | input | 1 | Register operands compare equal |
| pc_load | output | 1 | Final program counter load enable |
| pc_we | output | 1 | Unconditional PC write |
| pc_we_cond | output | 1 | PC write if operands equal |
| addr_from_alu | output | 1 | Memory address from ALU result register (else PC) |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| ir_we | output | 1 | Instruction register load |
| wb_from_mem | output | 1 | Register write data from memory data register |
| rf_we | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination is the rd field (else rt) |
| alu_a_reg | output | 1 | ALU A input from register A (else PC) |
| alu_b_sel | output | 2 | ALU B: 00 reg B, 01 four, 10 offset, 11 shifted offset |
| alu_op | output | 2 | 00 add, 01 compare, 10 function-field |
| tgt_we | output | 1 | Branch target register load |
| pc_src | output | 2 | 00 ALU, 01 target, 10 jump field |

## Verification
The branch step is the one place where a step strobe and a datapath flag meet in one cycle. There, pc_we_cond and ops_equal together decide pc_load, while the unconditional PC write of fetch and jump drives the same output on other cycles. The bench runs branches with the flag high and low. It also holds the flag high through register-type, memory and unknown-opcode instructions. Each cycle it compares pc_load against the rule that only fetch, jump or an equal branch may load the PC.

// File: rtl/mc_seq_pkg.sv
package mc_seq_pkg;

    localparam int OPC_W = 6;
    localparam int SEL_W = 2;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;

    localparam logic [SEL_W-1:0] BSEL_REG   = 2'b00;
    localparam logic [SEL_W-1:0] BSEL_FOUR  = 2'b01;
    localparam logic [SEL_W-1:0] BSEL_OFS   = 2'b10;
    localparam logic [SEL_W-1:0] BSEL_OFS_S = 2'b11;

    localparam logic [SEL_W-1:0] AOP_ADD  = 2'b00;
    localparam logic [SEL_W-1:0] AOP_CMP  = 2'b01;
    localparam logic [SEL_W-1:0] AOP_FUNC = 2'b10;

    localparam logic [SEL_W-1:0] PSRC_ALU = 2'b00;
    localparam logic [SEL_W-1:0] PSRC_TGT = 2'b01;
    localparam logic [SEL_W-1:0] PSRC_JMP = 2'b10;

    typedef enum logic [3:0] {
        ST_FETCH   = 4'd0,
        ST_DECODE  = 4'd1,
        ST_MADDR   = 4'd2,
        ST_MREAD   = 4'd3,
        ST_MLOADWB = 4'd4,
        ST_MSTORE  = 4'd5,
        ST_RALU    = 4'd6,
        ST_RDONE   = 4'd7,
        ST_BRANCH  = 4'd8,
        ST_JUMP    = 4'd9
    } step_e;

    typedef enum logic [2:0] {
        CL_RTYPE,
        CL_LOAD,
        CL_STORE,
        CL_BEQ,
        CL_JUMP,
        CL_OTHER
    } op_class_e;

    typedef struct packed {
        logic             pc_we;
        logic             pc_we_cond;
        logic             addr_from_alu;
        logic             mem_rd;
        logic             mem_wr;
        logic             ir_we;
        logic             wb_from_mem;
        logic             rf_we;
        logic             rf_dst_rd;
        logic             alu_a_reg;
        logic [SEL_W-1:0] alu_b_sel;
        logic [SEL_W-1:0] alu_op;
        logic             tgt_we;
        logic [SEL_W-1:0] pc_src;
    } strobe_t;

    typedef struct packed {
        step_e step;
    } seq_regs_t;

endpackage

// File: rtl/mc_op_class.sv
module mc_op_class
    import mc_seq_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output op_class_e        op_class
);
    always_comb begin
        case (opcode)
            OPC_RTYPE: op_class = CL_RTYPE;
            OPC_LOAD:  op_class = CL_LOAD;
            OPC_STORE: op_class = CL_STORE;
            OPC_BEQ:   op_class = CL_BEQ;
            OPC_JUMP:  op_class = CL_JUMP;
            default:   op_class = CL_OTHER;
        endcase
    end
endmodule

// File: rtl/mc_next_step.sv
module mc_next_step
    import mc_seq_pkg::*;
(
    input  step_e     cur_step,
    input  op_class_e op_class,
    output step_e     nxt_step
);
    always_comb begin
        nxt_step = ST_FETCH;
        case (cur_step)
            ST_FETCH:  nxt_step = ST_DECODE;
            ST_DECODE: begin
                case (op_class)
                    CL_RTYPE: nxt_step = ST_RALU;
                    CL_LOAD,
                    CL_STORE: nxt_step = ST_MADDR;
                    CL_BEQ:   nxt_step = ST_BRANCH;
                    CL_JUMP:  nxt_step = ST_JUMP;
                    default:  nxt_step = ST_FETCH;
                endcase
            end
            // address step branches again on load versus store
            ST_MADDR:  nxt_step = (op_class == CL_STORE) ? ST_MSTORE : ST_MREAD;
            ST_MREAD:  nxt_step = ST_MLOADWB;
            ST_RALU:   nxt_step = ST_RDONE;
            // terminal steps of every class
            ST_MLOADWB,
            ST_MSTORE,
            ST_RDONE,
            ST_BRANCH,
            ST_JUMP:   nxt_step = ST_FETCH;
            default:   nxt_step = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_strobe_gen.sv
module mc_strobe_gen
    import mc_seq_pkg::*;
(
    input  step_e   cur_step,
    output strobe_t strb
);
    always_comb begin
        // every strobe low and every select at its zero value unless set below
        strb = '0;
        case (cur_step)
            ST_FETCH: begin
                strb.mem_rd    = 1'b1;
                strb.ir_we     = 1'b1;
                strb.pc_we     = 1'b1;
                strb.alu_a_reg = 1'b0;
                strb.alu_b_sel = BSEL_FOUR;
                strb.alu_op    = AOP_ADD;
                strb.pc_src    = PSRC_ALU;
            end
            ST_DECODE: begin
                strb.alu_a_reg = 1'b0;
                strb.alu_b_sel = BSEL_OFS_S;
                strb.alu_op    = AOP_ADD;
                strb.tgt_we    = 1'b1;
            end
            ST_MADDR: begin
                strb.alu_a_reg = 1'b1;
                strb.alu_b_sel = BSEL_OFS;
                strb.alu_op    = AOP_ADD;
            end
            ST_MREAD: begin
                strb.mem_rd        = 1'b1;
                strb.addr_from_alu = 1'b1;
            end
            ST_MLOADWB: begin
                strb.rf_we       = 1'b1;
                strb.wb_from_mem = 1'b1;
                strb.rf_dst_rd   = 1'b0;
            end
            ST_MSTORE: begin
                strb.mem_wr        = 1'b1;
                strb.addr_from_alu = 1'b1;
            end
            ST_RALU: begin
                strb.alu_a_reg = 1'b1;
                strb.alu_b_sel = BSEL_REG;
                strb.alu_op    = AOP_FUNC;
            end
            ST_RDONE: begin
                strb.rf_we       = 1'b1;
                strb.rf_dst_rd   = 1'b1;
                strb.wb_from_mem = 1'b0;
            end
            ST_BRANCH: begin
                strb.pc_we_cond = 1'b1;
                strb.alu_a_reg  = 1'b1;
                strb.alu_b_sel  = BSEL_REG;
                strb.alu_op     = AOP_CMP;
                strb.pc_src     = PSRC_TGT;
            end
            ST_JUMP: begin
                strb.pc_we  = 1'b1;
                strb.pc_src = PSRC_JMP;
            end
            default: strb = '0;
        endcase
    end
endmodule

// File: rtl/mc_seq_ctrl.sv
module mc_seq_ctrl
    import mc_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OPC_W-1:0] opcode,
    input  logic             ops_equal,
    output logic             pc_load,
    output logic             pc_we,
    output logic             pc_we_cond,
    output logic             addr_from_alu,
    output logic             mem_rd,
    output logic             mem_wr,
    output logic             ir_we,
    output logic             wb_from_mem,
    output logic             rf_we,
    output logic             rf_dst_rd,
    output logic             alu_a_reg,
    output logic [SEL_W-1:0] alu_b_sel,
    output logic [SEL_W-1:0] alu_op,
    output logic             tgt_we,
    output logic [SEL_W-1:0] pc_src
);
    seq_regs_t regs_d, regs_q;
    op_class_e op_class;
    step_e     nxt_step;
    strobe_t   strb;

    mc_op_class u_class (
        .opcode   (opcode),
        .op_class (op_class)
    );

    mc_next_step u_next (
        .cur_step (regs_q.step),
        .op_class (op_class),
        .nxt_step (nxt_step)
    );

    mc_strobe_gen u_strobe (
        .cur_step (regs_q.step),
        .strb     (strb)
    );

    always_comb begin
        regs_d      = regs_q;
        regs_d.step = nxt_step;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q.step <= ST_FETCH;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pc_we         = strb.pc_we;
    assign pc_we_cond    = strb.pc_we_cond;
    assign addr_from_alu = strb.addr_from_alu;
    assign mem_rd        = strb.mem_rd;
    assign mem_wr        = strb.mem_wr;
    assign ir_we         = strb.ir_we;
    assign wb_from_mem   = strb.wb_from_mem;
    assign rf_we         = strb.rf_we;
    assign rf_dst_rd     = strb.rf_dst_rd;
    assign alu_a_reg     = strb.alu_a_reg;
    assign alu_b_sel     = strb.alu_b_sel;
    assign alu_op        = strb.alu_op;
    assign tgt_we        = strb.tgt_we;
    assign pc_src        = strb.pc_src;
    assign pc_load       = strb.pc_we | (strb.pc_we_cond & ops_equal);
endmodule

// File: rtl/mc_seq_ctrl_chk.sv
module mc_seq_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       ops_equal,
    input logic       pc_load,
    input logic       pc_we,
    input logic       pc_we_cond,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       ir_we,
    input logic       rf_we,
    input logic       tgt_we,
    input logic [1:0] alu_op,
    input logic [1:0] pc_src
);
    assert_excl_rw_R10: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));

    assert_fetch_then_decode_R2: assert property (@(posedge clk) disable iff (rst)
        ir_we |=> tgt_we);

    assert_fetch_pc_src_R2: assert property (@(posedge clk) disable iff (rst)
        (pc_we && ir_we) |-> (pc_src == 2'b00));

    assert_target_ready_R7: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |-> $past(tgt_we));

    assert_branch_sel_R7: assert property (@(posedge clk) disable iff (rst)
        pc_we_cond |-> (pc_src == 2'b01 && alu_op == 2'b01));

    assert_eq_gate_R9: assert property (@(posedge clk) disable iff (rst)
        (pc_load && !pc_we) |-> (pc_we_cond && ops_equal));

    assert_load_return_R4: assert property (@(posedge clk) disable iff (rst)
        rf_we |=> ir_we);

    assert_store_return_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr |=> ir_we);

    assert_jump_return_R8: assert property (@(posedge clk) disable iff (rst)
        (pc_we && pc_src == 2'b10) |=> ir_we);
endmodule

bind mc_seq_ctrl mc_seq_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ops_equal  (ops_equal),
    .pc_load    (pc_load),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .ir_we      (ir_we),
    .rf_we      (rf_we),
    .tgt_we     (tgt_we),
    .alu_op     (alu_op),
    .pc_src     (pc_src)
);

// File: tb/mc_seq_ctrl_tb.sv
module mc_seq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'd0;
    logic       ops_equal = 1'b0;
    logic       pc_load, pc_we, pc_we_cond, addr_from_alu, mem_rd, mem_wr, ir_we;
    logic       wb_from_mem, rf_we, rf_dst_rd, alu_a_reg, tgt_we;
    logic [1:0] alu_b_sel, alu_op, pc_src;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [16:0] exp_q [$];
    string       tag_q [$];

    always #5 clk = ~clk;

    mc_seq_ctrl u_dut (
        .clk(clk), .rst(rst), .opcode(opcode), .ops_equal(ops_equal),
        .pc_load(pc_load), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .addr_from_alu(addr_from_alu), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .ir_we(ir_we), .wb_from_mem(wb_from_mem), .rf_we(rf_we),
        .rf_dst_rd(rf_dst_rd), .alu_a_reg(alu_a_reg), .alu_b_sel(alu_b_sel),
        .alu_op(alu_op), .tgt_we(tgt_we), .pc_src(pc_src)
    );

    // word layout: pcw cond afa mrd mwr irw w2m rfw rdst asel bsel[2] aop[2] tw psrc[2]
    function automatic logic [16:0] mk(input logic pcw, cond, afa, mrd, mwr, irw,
                                       w2m, rfw, rdst, asel, input logic [1:0] bsel,
                                       aop, input logic tw, input logic [1:0] psrc);
        return {pcw, cond, afa, mrd, mwr, irw, w2m, rfw, rdst, asel, bsel, aop, tw, psrc};
    endfunction

    function automatic logic [16:0] w_fetch();  return mk(1,0,0,1,0,1,0,0,0,0,2'b01,2'b00,0,2'b00); endfunction
    function automatic logic [16:0] w_decode(); return mk(0,0,0,0,0,0,0,0,0,0,2'b11,2'b00,1,2'b00); endfunction

    task automatic push(input logic [16:0] w, input string t);
        exp_q.push_back(w);
        tag_q.push_back(t);
    endtask

    task automatic run_instr(input logic [5:0] op, input logic eq);
        opcode    = op;
        ops_equal = eq;
        push(w_fetch(), "R2");
        push(w_decode(), "R3");
        case (op)
            6'b100011: begin
                push(mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,0,2'b00), "R4");
                push(mk(0,0,1,1,0,0,0,0,0,0,2'b00,2'b00,0,2'b00), "R4");
                push(mk(0,0,0,0,0,0,1,1,0,0,2'b00,2'b00,0,2'b00), "R4");
            end
            6'b101011: begin
                push(mk(0,0,0,0,0,0,0,0,0,1,2'b10,2'b00,0,2'b00), "R5");
                push(mk(0,0,1,0,1,0,0,0,0,0,2'b00,2'b00,0,2'b00), "R5");
            end
            6'b000000: begin
                push(mk(0,0,0,0,0,0,0,0,0,1,2'b00,2'b10,0,2'b00), "R6");
                push(mk(0,0,0,0,0,0,0,1,1,0,2'b00,2'b00,0,2'b00), "R6");
            end
            6'b000100: push(mk(0,1,0,0,0,0,0,0,0,1,2'b00,2'b01,0,2'b01), "R7");
            6'b000010: push(mk(1,0,0,0,0,0,0,0,0,0,2'b00,2'b00,0,2'b10), "R8");
            default: ;
        endcase
        while (exp_q.size() > 0) begin
            logic [16:0] w;
            logic [17:0] exp_full, act_full;
            string t;
            w = exp_q.pop_front();
            t = tag_q.pop_front();
            #1;
            exp_full = {w[16] | (w[15] & eq), w};
            act_full = {pc_load, pc_we, pc_we_cond, addr_from_alu, mem_rd, mem_wr, ir_we,
                        wb_from_mem, rf_we, rf_dst_rd, alu_a_reg, alu_b_sel, alu_op,
                        tgt_we, pc_src};
            n_cmp++;
            if (act_full !== exp_full) begin
                n_bad++;
                $display("FAIL %s/R9/R10 op=%b eq=%0d actual=%b expected=%b",
                         t, op, eq, act_full, exp_full);
            end
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000 && !finished) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<5000 cycles", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        // R1: fetch strobes while held in reset
        n_cmp++;
        if ({ir_we, mem_rd, pc_we, tgt_we, rf_we} !== 5'b11100) begin
            n_bad++;
            $display("FAIL R1 actual=%b expected=11100",
                     {ir_we, mem_rd, pc_we, tgt_we, rf_we});
        end
        rst = 1'b0;
        run_instr(6'b000000, 1'b0);
        run_instr(6'b100011, 1'b0);
        run_instr(6'b101011, 1'b0);
        run_instr(6'b000100, 1'b1);
        run_instr(6'b000100, 1'b0);
        run_instr(6'b000010, 1'b0);
        run_instr(6'b111111, 1'b0);
        run_instr(6'b000001, 1'b1);
        // R9: equality high through non-branch classes
        run_instr(6'b000000, 1'b1);
        run_instr(6'b100011, 1'b1);
        run_instr(6'b101011, 1'b1);
        run_instr(6'b000010, 1'b1);
        // R1: reset mid-instruction returns to fetch
        opcode = 6'b100011;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        run_instr(6'b000100, 1'b1);
        run_instr(6'b000000, 1'b0);
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule